// File: doc/BRIEF.md
# CCD Fast Readout Line Sequencer

This block orders the vertical lines of a CCD frame in the fast readout modes. Each frame is divided into up to three phases. In the frame-shift phase, rows above the wanted band are moved out at high speed. In the window phase, one output line is produced per horizontal line. In the sweep phase, the rows below the band are cleared. The block is counted by an external line tick. A mode code chooses between two kinds of frame:

- The subsampled mode has only a window. It is one long window of subsampled lines.
- The two autofocus modes place a short window, fixed in position, between a shift burst and a sweep burst.

The frame-shift and sweep phases produce high-speed vertical transfer pulse trains. The window lines produce one normal line-transfer strobe each. The block also reports the following:

- a line-valid flag
- a frame-start pulse
- the output line number
- the first sensor row summed into that line

The subsampling reads two pairs of same-colour rows in every group of twelve rows. Each pair is summed into one output line. This gives two output lines per group.

Top module: `ccd_fastread_seq`

## Requirements
- R1: While `rst` is high, and afterwards until the first `line_tick`, the outputs have these values: `frame_start`, `line_valid`, `vt_line` and `vt_burst` are 0, and `out_line` and `row_first` are 0. The first `line_tick` after reset begins a frame.
- R2: All outputs have a latency of one cycle. An effect of a tick sampled at clock edge E becomes visible after edge E+1. `frame_start` is high for exactly that one cycle after a tick that begins a frame. A tick begins a frame when it is the first tick after reset, or when it is the tick after the last line of the previous frame.
- R3: Modes 0 and 3 of `mode_sel` are the subsampled mode. In this mode a frame is FAST_LINES window lines, starting with the frame's first line. The mode has no shift or sweep lines, and `vt_burst` stays 0.
- R4: Mode 1 (AF1) runs three phases in order. First come AF1_SHIFT_LINES shift lines. Then comes a window of AF1_LINES_N lines when `pal_sel`=0, or AF1_LINES_P lines when `pal_sel`=1. Last come AF1_SWEEP_LINES sweep lines.
- R5: Mode 2 (AF2) runs three phases in order. First come AF2_SHIFT_LINES shift lines. Then comes a window of AF2_LINES_N lines when `pal_sel`=0, or AF2_LINES_P lines when `pal_sel`=1. Last come AF2_SWEEP_LINES sweep lines.
- R6: On the first line of a shift phase, `vt_burst` produces the mode's shift transfer count of pulses: AF1_SHIFT_XFER or AF2_SHIFT_XFER. On the first line of a sweep phase, it produces the mode's sweep count: AF1_SWEEP_XFER or AF2_SWEEP_XFER. Each pulse is high for BURST_HIGH cycles within a BURST_PERIOD-cycle repeat. No pulses occur during window lines.
- R7: `out_line` is 0 on the first window line of a frame. It increases by 1 on each following window line. It is cleared to 0 at every frame start.
- R8: On window line k, `row_first` = base + GROUP_ROWS*(k/2) + (k odd ? PAIR_OFFSET : 0). The value base is the mode's shift transfer count, and is 0 in the subsampled mode.
- R9: `line_valid` is high for exactly the window lines. `vt_line` is a one-cycle pulse at the start of each window line.
- R10: `mode_sel` and `pal_sel` are sampled only by the tick that begins a frame. A change during a frame takes effect at the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| line_tick | input | 1 | One-cycle pulse per horizontal line |
| mode_sel | input | 2 | 0/3 subsampled, 1 AF1, 2 AF2 |
| pal_sel | input | 1 | 0 = 60 Hz line counts, 1 = 50 Hz line counts |
| vt_line | output | 1 | Normal line-transfer strobe for each window line |
| vt_burst | output | 1 | High-speed vertical transfer pulse train |
| line_valid | output | 1 | High during window lines |
| frame_start | output | 1 | One-cycle pulse at frame begin |
| out_line | output | 12 | Output line index within the window |
| row_first | output | 12 | First sensor row summed into the current output line |

## Verification
The bench shrinks the line counts, as follows:

- subsampled window: 12 lines
- AF1 window: 5 lines at 60 Hz, 7 lines at 50 Hz
- AF2 window: 3 lines at 60 Hz, 4 lines at 50 Hz
- shift and sweep phases: 2 to 3 lines each, with transfer counts of 6 to 10

It also cuts the burst pulses to 5 high cycles in an 8-cycle repeat. With these values every phase transition, every frame wrap and every burst end falls inside a few thousand cycles. The grouping constants GROUP_ROWS and PAIR_OFFSET keep their real values of 12 and 7, so the row arithmetic is exercised as built. The short bursts finish well inside one 100-cycle line. This allows exact pulse counts and widths to be checked for each phase. It also allows mid-frame mode changes and a mid-frame reset to be tested.

// File: rtl/ccdro_pkg.sv
package ccdro_pkg;

    localparam int CNT_W = 12;

    typedef logic [CNT_W-1:0] cnt_t;

    typedef enum logic [1:0] {
        MODE_FAST     = 2'd0,
        MODE_AF1      = 2'd1,
        MODE_AF2      = 2'd2,
        MODE_FAST_ALT = 2'd3
    } rd_mode_t;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_SHIFT  = 2'd1,
        PH_WINDOW = 2'd2,
        PH_SWEEP  = 2'd3
    } phase_t;

    typedef struct packed {
        cnt_t shift_lines;
        cnt_t win_lines;
        cnt_t sweep_lines;
        cnt_t shift_xfer;
        cnt_t sweep_xfer;
    } frame_cfg_t;

    // First summed sensor row for window line k
    function automatic cnt_t row_of(cnt_t base, cnt_t k, cnt_t group, cnt_t pair);
        cnt_t grp_idx;
        grp_idx = k >> 1;
        return base + group * grp_idx + (k[0] ? pair : '0);
    endfunction

endpackage

// File: rtl/ccdro_burst.sv
module ccdro_burst
    import ccdro_pkg::*;
#(
    parameter int PERIOD = 80,
    parameter int HIGH   = 48
) (
    input  logic clk,
    input  logic rst,
    input  logic go,
    input  cnt_t len,
    output logic pulse
);
    localparam int POS_W = (PERIOD > 2) ? $clog2(PERIOD) : 1;
    localparam logic [POS_W-1:0] POS_LAST = POS_W'(PERIOD - 1);
    localparam logic [POS_W-1:0] POS_HIGH = POS_W'(HIGH);

    logic             active;
    logic [POS_W-1:0] pos;
    cnt_t             npulse;
    cnt_t             len_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            pos    <= '0;
            npulse <= '0;
            len_q  <= '0;
        end else if (go) begin
            active <= (len != '0);
            pos    <= '0;
            npulse <= '0;
            len_q  <= len;
        end else if (active) begin
            if (pos == POS_LAST) begin
                pos    <= '0;
                npulse <= npulse + cnt_t'(1);
                if (npulse == len_q - cnt_t'(1))
                    active <= 1'b0;
            end else begin
                pos <= pos + POS_W'(1);
            end
        end
    end

    assign pulse = active && (pos < POS_HIGH);

    AST_BURST_COUNT: assert property (@(posedge clk) disable iff (rst)
        active |-> (npulse < len_q)); // R6

endmodule

// File: rtl/ccdro_seq.sv
module ccdro_seq
    import ccdro_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       line_tick,
    input  frame_cfg_t cfg_req,
    output phase_t     phase,
    output logic       frame_go,
    output logic       win_first,
    output logic       win_tick,
    output logic       burst_go,
    output cnt_t       burst_len,
    output cnt_t       row_base
);
    frame_cfg_t cfg, nxt_cfg;
    cnt_t       lcnt, nxt_lcnt;
    phase_t     nxt_phase;
    logic       start;

    always_comb begin
        start     = 1'b0;
        nxt_phase = phase;
        nxt_lcnt  = lcnt + cnt_t'(1);
        nxt_cfg   = cfg;
        unique case (phase)
            PH_IDLE: start = 1'b1;
            PH_SHIFT: begin
                if (lcnt == cfg.shift_lines - cnt_t'(1)) begin
                    nxt_phase = PH_WINDOW;
                    nxt_lcnt  = '0;
                end
            end
            PH_WINDOW: begin
                if (lcnt == cfg.win_lines - cnt_t'(1)) begin
                    if (cfg.sweep_lines != '0) begin
                        nxt_phase = PH_SWEEP;
                        nxt_lcnt  = '0;
                    end else begin
                        start = 1'b1;
                    end
                end
            end
            PH_SWEEP: begin
                if (lcnt == cfg.sweep_lines - cnt_t'(1))
                    start = 1'b1;
            end
            default: start = 1'b1;
        endcase
        if (start) begin
            nxt_cfg   = cfg_req;
            nxt_phase = (cfg_req.shift_lines != '0) ? PH_SHIFT : PH_WINDOW;
            nxt_lcnt  = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase     <= PH_IDLE;
            lcnt      <= '0;
            cfg       <= '0;
            frame_go  <= 1'b0;
            win_first <= 1'b0;
            win_tick  <= 1'b0;
            burst_go  <= 1'b0;
            burst_len <= '0;
        end else begin
            frame_go  <= 1'b0;
            win_first <= 1'b0;
            win_tick  <= 1'b0;
            burst_go  <= 1'b0;
            if (line_tick) begin
                phase     <= nxt_phase;
                lcnt      <= nxt_lcnt;
                cfg       <= nxt_cfg;
                frame_go  <= start;
                win_tick  <= (nxt_phase == PH_WINDOW);
                win_first <= (nxt_phase == PH_WINDOW) && (start || phase != PH_WINDOW);
                if (start && nxt_phase == PH_SHIFT) begin
                    burst_go  <= 1'b1;
                    burst_len <= nxt_cfg.shift_xfer;
                end else if (nxt_phase == PH_SWEEP && phase != PH_SWEEP) begin
                    burst_go  <= 1'b1;
                    burst_len <= cfg.sweep_xfer;
                end
            end
        end
    end

    assign row_base = cfg.shift_xfer;

    AST_CFG_ONLY_AT_FRAME: assert property (@(posedge clk) disable iff (rst)
        !$stable(cfg) |-> frame_go); // R10

    AST_WINDOW_BOUND: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_WINDOW) |-> (lcnt < cfg.win_lines)); // R9

endmodule

// File: rtl/ccdro_addr.sv
module ccdro_addr
    import ccdro_pkg::*;
#(
    parameter int GROUP_ROWS  = 12,
    parameter int PAIR_OFFSET = 7
) (
    input  logic clk,
    input  logic rst,
    input  logic frame_go,
    input  logic win_first,
    input  logic win_tick,
    input  logic in_window,
    input  cnt_t row_base,
    output logic frame_start,
    output logic line_valid,
    output logic vt_line,
    output cnt_t out_line,
    output cnt_t row_first
);
    localparam cnt_t GROUP_C = cnt_t'(GROUP_ROWS);
    localparam cnt_t PAIR_C  = cnt_t'(PAIR_OFFSET);

    cnt_t k_next;

    assign k_next = win_first ? '0 : out_line + cnt_t'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            frame_start <= 1'b0;
            line_valid  <= 1'b0;
            vt_line     <= 1'b0;
            out_line    <= '0;
            row_first   <= '0;
        end else begin
            frame_start <= frame_go;
            line_valid  <= in_window;
            vt_line     <= win_tick;
            if (win_tick) begin
                out_line  <= k_next;
                row_first <= row_of(row_base, k_next, GROUP_C, PAIR_C);
            end else if (frame_go) begin
                out_line  <= '0;
                row_first <= '0;
            end
        end
    end

    AST_VTLINE_IN_WINDOW: assert property (@(posedge clk) disable iff (rst)
        vt_line |-> line_valid); // R9

    AST_OUTLINE_STEP: assert property (@(posedge clk) disable iff (rst)
        (vt_line && out_line != '0) |-> (out_line == $past(out_line) + cnt_t'(1))); // R7

endmodule

// File: rtl/ccd_fastread_seq.sv
module ccd_fastread_seq
    import ccdro_pkg::*;
#(
    parameter int BURST_PERIOD    = 80,
    parameter int BURST_HIGH      = 48,
    parameter int FAST_LINES      = 258,
    parameter int AF1_LINES_N     = 117,
    parameter int AF1_LINES_P     = 145,
    parameter int AF2_LINES_N     = 33,
    parameter int AF2_LINES_P     = 47,
    parameter int AF1_SHIFT_LINES = 10,
    parameter int AF2_SHIFT_LINES = 17,
    parameter int AF1_SWEEP_LINES = 11,
    parameter int AF2_SWEEP_LINES = 17,
    parameter int AF1_SHIFT_XFER  = 68,
    parameter int AF2_SHIFT_XFER  = 110,
    parameter int AF1_SWEEP_XFER  = 75,
    parameter int AF2_SWEEP_XFER  = 116,
    parameter int GROUP_ROWS      = 12,
    parameter int PAIR_OFFSET     = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             line_tick,
    input  logic [1:0]       mode_sel,
    input  logic             pal_sel,
    output logic             vt_line,
    output logic             vt_burst,
    output logic             line_valid,
    output logic             frame_start,
    output logic [CNT_W-1:0] out_line,
    output logic [CNT_W-1:0] row_first
);
    frame_cfg_t cfg_req;
    phase_t     phase;
    logic       frame_go, win_first, win_tick, burst_go;
    cnt_t       burst_len, row_base;

    always_comb begin
        unique case (rd_mode_t'(mode_sel))
            MODE_AF1: cfg_req = '{
                shift_lines: cnt_t'(AF1_SHIFT_LINES),
                win_lines:   pal_sel ? cnt_t'(AF1_LINES_P) : cnt_t'(AF1_LINES_N),
                sweep_lines: cnt_t'(AF1_SWEEP_LINES),
                shift_xfer:  cnt_t'(AF1_SHIFT_XFER),
                sweep_xfer:  cnt_t'(AF1_SWEEP_XFER)};
            MODE_AF2: cfg_req = '{
                shift_lines: cnt_t'(AF2_SHIFT_LINES),
                win_lines:   pal_sel ? cnt_t'(AF2_LINES_P) : cnt_t'(AF2_LINES_N),
                sweep_lines: cnt_t'(AF2_SWEEP_LINES),
                shift_xfer:  cnt_t'(AF2_SHIFT_XFER),
                sweep_xfer:  cnt_t'(AF2_SWEEP_XFER)};
            default: cfg_req = '{
                shift_lines: '0,
                win_lines:   cnt_t'(FAST_LINES),
                sweep_lines: '0,
                shift_xfer:  '0,
                sweep_xfer:  '0};
        endcase
    end

    ccdro_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .line_tick (line_tick),
        .cfg_req   (cfg_req),
        .phase     (phase),
        .frame_go  (frame_go),
        .win_first (win_first),
        .win_tick  (win_tick),
        .burst_go  (burst_go),
        .burst_len (burst_len),
        .row_base  (row_base)
    );

    ccdro_burst #(
        .PERIOD (BURST_PERIOD),
        .HIGH   (BURST_HIGH)
    ) u_burst (
        .clk   (clk),
        .rst   (rst),
        .go    (burst_go),
        .len   (burst_len),
        .pulse (vt_burst)
    );

    ccdro_addr #(
        .GROUP_ROWS  (GROUP_ROWS),
        .PAIR_OFFSET (PAIR_OFFSET)
    ) u_addr (
        .clk         (clk),
        .rst         (rst),
        .frame_go    (frame_go),
        .win_first   (win_first),
        .win_tick    (win_tick),
        .in_window   (phase == PH_WINDOW),
        .row_base    (row_base),
        .frame_start (frame_start),
        .line_valid  (line_valid),
        .vt_line     (vt_line),
        .out_line    (out_line),
        .row_first   (row_first)
    );

    AST_FS_SINGLE: assert property (@(posedge clk) disable iff (rst)
        frame_start |=> !frame_start); // R2

endmodule

// File: tb/tb_ccd_fastread_seq.sv
`timescale 1ns/1ps
module tb_ccd_fastread_seq;

    localparam int P_PER   = 8;
    localparam int P_HIGH  = 5;
    localparam int FASTN   = 12;
    localparam int A1N = 5, A1P = 7, A2N = 3, A2P = 4;
    localparam int A1SH = 2, A2SH = 3, A1SW = 2, A2SW = 3;
    localparam int A1SX = 6, A2SX = 9, A1WX = 7, A2WX = 10;
    localparam int GRP = 12, PAIR = 7;
    localparam int LINE_GAP = 100;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic line_tick = 1'b0;
    logic [1:0] mode_sel = 2'd0;
    logic pal_sel = 1'b0;
    logic vt_line, vt_burst, line_valid, frame_start;
    logic [11:0] out_line, row_first;

    int nchk = 0;
    int nerr = 0;
    int rises = 0;
    int widths = 0;
    int werr = 0;
    int run = 0;
    logic prev = 1'b0;

    always #2.5 clk = ~clk;

    ccd_fastread_seq #(
        .BURST_PERIOD(P_PER), .BURST_HIGH(P_HIGH), .FAST_LINES(FASTN),
        .AF1_LINES_N(A1N), .AF1_LINES_P(A1P), .AF2_LINES_N(A2N), .AF2_LINES_P(A2P),
        .AF1_SHIFT_LINES(A1SH), .AF2_SHIFT_LINES(A2SH),
        .AF1_SWEEP_LINES(A1SW), .AF2_SWEEP_LINES(A2SW),
        .AF1_SHIFT_XFER(A1SX), .AF2_SHIFT_XFER(A2SX),
        .AF1_SWEEP_XFER(A1WX), .AF2_SWEEP_XFER(A2WX),
        .GROUP_ROWS(GRP), .PAIR_OFFSET(PAIR)
    ) dut (
        .clk(clk), .rst(rst), .line_tick(line_tick), .mode_sel(mode_sel),
        .pal_sel(pal_sel), .vt_line(vt_line), .vt_burst(vt_burst),
        .line_valid(line_valid), .frame_start(frame_start),
        .out_line(out_line), .row_first(row_first)
    );

    // burst pulse monitor
    always @(negedge clk) begin
        if (vt_burst && !prev) rises = rises + 1;
        if (vt_burst) run = run + 1;
        else begin
            if (prev) begin
                widths = widths + 1;
                if (run != P_HIGH) werr = werr + 1;
            end
            run = 0;
        end
        prev = vt_burst;
    end

    task automatic chk(input string req, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // pulse one tick; return at the negedge after the output edge
    task automatic tick_and_wait_out();
        @(negedge clk);
        line_tick = 1'b1;
        @(negedge clk);
        line_tick = 1'b0;
        @(negedge clk);
    endtask

    task automatic gap();
        repeat (LINE_GAP) @(negedge clk);
    endtask

    task automatic test_reset();
        rst = 1'b1;
        repeat (4) @(negedge clk);
        chk("R1 frame_start in reset", int'(frame_start), 0);
        chk("R1 line_valid in reset", int'(line_valid), 0);
        rst = 1'b0;
        repeat (20) @(negedge clk);
        chk("R1 frame_start idle", int'(frame_start), 0);
        chk("R1 line_valid idle", int'(line_valid), 0);
        chk("R1 vt_line idle", int'(vt_line), 0);
        chk("R1 vt_burst idle", int'(vt_burst), 0);
        chk("R1 out_line idle", int'(out_line), 0);
        chk("R1 row_first idle", int'(row_first), 0);
    endtask

    // run one complete frame; mode changes to m_mid after the first tick
    task automatic run_frame(input int m, input int p, input int m_mid, input string tag);
        int e_sh, e_win, e_sw, e_sx, e_wx, total;
        int s0, s1, s2, s3;
        e_sh = 0; e_win = FASTN; e_sw = 0; e_sx = 0; e_wx = 0;
        if (m == 1) begin e_sh = A1SH; e_win = (p != 0) ? A1P : A1N; e_sw = A1SW; e_sx = A1SX; e_wx = A1WX; end
        if (m == 2) begin e_sh = A2SH; e_win = (p != 0) ? A2P : A2N; e_sw = A2SW; e_sx = A2SX; e_wx = A2WX; end
        total = e_sh + e_win + e_sw;
        mode_sel = 2'(m);
        pal_sel = p[0];
        s0 = 0; s1 = 0; s2 = 0;
        for (int i = 0; i < total; i++) begin
            @(negedge clk); #1;
            if (i == 0) s0 = rises;
            if (i == e_sh) s1 = rises;
            if (i == e_sh + e_win) s2 = rises;
            tick_and_wait_out();
            if (i == 0) mode_sel = 2'(m_mid);
            chk({tag, " R2 frame_start"}, int'(frame_start), (i == 0) ? 1 : 0);
            if (i >= e_sh && i < e_sh + e_win) begin
                int k;
                int er;
                k = i - e_sh;
                er = e_sx + GRP * (k / 2) + ((k % 2 == 1) ? PAIR : 0);
                chk({tag, " R9 line_valid window"}, int'(line_valid), 1);
                chk({tag, " R9 vt_line"}, int'(vt_line), 1);
                chk({tag, " R7 out_line"}, int'(out_line), k);
                chk({tag, " R8 row_first"}, int'(row_first), er);
            end else begin
                chk({tag, " R9 line_valid outside"}, int'(line_valid), 0);
                chk({tag, " R9 vt_line outside"}, int'(vt_line), 0);
                if (i == 0) chk({tag, " R7 out_line cleared"}, int'(out_line), 0);
            end
            @(negedge clk);
            chk({tag, " R2 frame_start one cycle"}, int'(frame_start), 0);
            chk({tag, " R9 vt_line one cycle"}, int'(vt_line), 0);
            gap();
        end
        @(negedge clk); #1;
        s3 = rises;
        if (e_sh == 0) s1 = s0;
        if (e_sw == 0) s2 = s3;
        chk({tag, " R6 shift pulses"}, s1 - s0, e_sx);
        chk({tag, " R6 window pulses"}, s2 - s1, 0);
        chk({tag, " R6 sweep pulses"}, s3 - s2, e_wx);
        if (m == 1) chk({tag, " R4 frame lines"}, total, A1SH + e_win + A1SW);
        if (m == 2) chk({tag, " R5 frame lines"}, total, A2SH + e_win + A2SW);
        if (m == 0 || m == 3) chk({tag, " R3 no bursts"}, s3 - s0, 0);
    endtask

    task automatic test_mid_reset();
        mode_sel = 2'd1;
        pal_sel = 1'b0;
        tick_and_wait_out();
        gap();
        tick_and_wait_out();
        gap();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 line_valid after mid reset", int'(line_valid), 0);
        chk("R1 out_line after mid reset", int'(out_line), 0);
        chk("R1 frame_start after mid reset", int'(frame_start), 0);
    endtask

    task automatic test_width();
        chk("R6 pulse widths seen", int'(widths > 0), 1);
        chk("R6 pulse width errors", werr, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nchk++;
        nerr++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

    initial begin
        test_reset();
        run_frame(0, 0, 0, "fast ntsc R3");
        run_frame(3, 1, 3, "fast alt R3");
        run_frame(1, 0, 1, "af1 ntsc R4");
        run_frame(1, 1, 1, "af1 pal R4");
        run_frame(2, 0, 0, "af2 ntsc midchange R10 R5");
        run_frame(0, 0, 2, "fast after change R10");
        run_frame(2, 1, 2, "af2 pal R5");
        test_mid_reset();
        run_frame(1, 1, 1, "af1 after reset R1");
        test_width();
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

endmodule